// File: doc/BRIEF.md
# Multi-Slot SPI Master with Per-Slot Frame Settings

The block is an SPI master that drives a shared serial clock and data-out line and serves several peripherals, each behind its own active-low chip select. Every peripheral (a "slot") has a configuration word. The word sets whether the slot is usable, its clock polarity, its word width, which end of the word goes out first, whether the receive path listens to its own output instead of the input pin, and its serial clock rate.

Work arrives as a stream of {slot, data} words. For each accepted word the block loads the frame settings of the addressed slot. It selects that peripheral and runs one full-duplex transfer. It then presents {slot, received data} on a one-cycle result strobe, together with a completion pulse. The settings are loaded again for each word, so consecutive words may go to different slots with different formats. A later write to a slot's configuration does not change a transfer that is already running.

Top module: `spim_master`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` as the configuration of slot `cfg_sel`. The fields are: bit 0 = enable, bits 2:1 = clock mode, bits 4:3 = length, bit 5 = bit order, bit 6 = loopback, bits 31:16 = divider. All slots are disabled after reset.
- R2: `in_ready` is high exactly when `busy` is low. An accepted word for an enabled slot drives that slot's `cs_n` bit low and all other bits high. `busy` is high from the cycle of assertion up to the cycle of release.
- R3: A length field of 00 selects 32 bits, 01 selects 16 bits, and 10 or 11 selects 8 bits. A transfer of N bits makes exactly N rising SCLK edges. Only the low N bits of `in_data` are sent, and received bits above N-1 read as zero.
- R4: A bit-order value of 0 sends bit N-1 first and a value of 1 sends bit 0 first. Received bits are placed at the positions they were sent from.
- R5: With loopback set, the receive shifter takes `mosi` and `miso` is ignored. With loopback clear, it takes `miso`.
- R6: Let h = floor(max(divider,2)/2). Every SCLK half period lasts h system clocks. The first SCLK edge comes h clocks after chip-select assertion, and the release comes h clocks after the last edge.
- R7: A mode value of 11 selects mode 3, in which SCLK idles high. Any other value selects mode 0, in which SCLK idles low. SCLK takes the slot's idle level in the cycle chip select asserts and is back at that level at release. Data is sampled on rising edges, and `mosi` changes only when SCLK falls or when a word is accepted.
- R8: In the cycle chip select is released, `out_valid` and `done` pulse high for one cycle, with `out_slot` and `out_data` holding the result.
- R9: A word accepted for a disabled slot is dropped. No chip select or SCLK toggles, `busy` stays low, and no result is produced.
- R10: The frame settings are captured when a word is accepted. Rewriting that slot's configuration during the transfer does not affect it, and the next word uses the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SLOT_W | Slot whose configuration is written |
| cfg_data | input | 32 | Configuration word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| in_slot | input | SLOT_W | Target slot of the input word |
| in_data | input | 32 | Data to send, right-aligned |
| out_valid | output | 1 | Result strobe (one cycle) |
| out_slot | output | SLOT_W | Slot of the result |
| out_data | output | 32 | Received data, right-aligned |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NSLOTS | Active-low chip selects, one per slot |

## Verification
The bench builds the block with its defaults: eight slots and a 3-bit slot index. This lets every chip-select line and every field combination be reached within one run. The bench's serial model ties `miso` to the inverse of `mosi`, so a loopback slot and a pin-reading slot return different values for the same word, which shows which source the receiver used. Dividers of 0, 4, 8, 16 and 128 cover the clamp to 2, the short half periods and the long ones. Writing a configuration word during a transfer and sending to a disabled slot cover the capture rule and the drop rule.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_W  = $clog2(WORD_W) + 1;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int DIV_W  = 16;
  localparam int HALF_W = DIV_W - 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             lb;
    logic             lsb;
    logic [1:0]       len;
    logic             cpol;
    logic             en;
  } slot_cfg_t;

  function automatic slot_cfg_t cfg_decode(input logic [31:0] w);
    slot_cfg_t c;
    c.en   = w[0];
    c.cpol = (w[2:1] == 2'b11);
    c.len  = w[4:3];
    c.lsb  = w[5];
    c.lb   = w[6];
    c.div  = w[31:16];
    return c;
  endfunction

  function automatic logic [BIT_W-1:0] len_bits(input logic [1:0] l);
    case (l)
      2'b00:   return BIT_W'(32);
      2'b01:   return BIT_W'(16);
      default: return BIT_W'(8);
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] half_of(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] e;
    e = (d < DIV_W'(2)) ? DIV_W'(2) : d;
    return e[DIV_W-1:1];
  endfunction
endpackage

// File: rtl/spim_cfg_bank.sv
module spim_cfg_bank
  import spim_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] wsel,
  input  logic [31:0]       wdata,
  input  logic [SLOT_W-1:0] rsel,
  output slot_cfg_t         rcfg
);
  slot_cfg_t regs [NSLOTS];

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        regs[s] <= '0;
      else if (we && (wsel == SLOT_W'(s)))
        regs[s] <= cfg_decode(wdata);
    end
  end

  always_comb begin
    rcfg = '0;
    for (int s = 0; s < NSLOTS; s++)
      if (rsel == SLOT_W'(s)) rcfg = regs[s];
  end
endmodule

// File: rtl/spim_halfper.sv
module spim_halfper #(
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && !restart && (cnt == half - HW'(1));

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (run)
      cnt <= tick ? '0 : cnt + HW'(1);
  end
endmodule

// File: rtl/spim_bitpos.sv
module spim_bitpos
  import spim_pkg::*;
(
  input  logic [BIT_W-1:0] k,
  input  logic [BIT_W-1:0] nbits,
  input  logic             lsb,
  output logic [IDX_W-1:0] idx
);
  logic [BIT_W-1:0] from_top;

  always_comb begin
    from_top = nbits - k - BIT_W'(1);
    idx      = lsb ? k[IDX_W-1:0] : from_top[IDX_W-1:0];
  end
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int  NSLOTS = 8,
  localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_sel,
  input  logic [31:0]       cfg_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  output logic [SLOT_W-1:0] out_slot,
  output logic [31:0]       out_data,
  output logic              done,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NSLOTS-1:0] cs_n
);
  localparam int ECNT_W = BIT_W + 1;

  slot_cfg_t sel_cfg;

  logic [SLOT_W-1:0] cur_slot;
  logic [BIT_W-1:0]  cur_nbits;
  logic              cur_lsb;
  logic              cur_lb;
  logic [HALF_W-1:0] cur_half;
  logic [WORD_W-1:0] txd;
  logic [WORD_W-1:0] rxd;
  logic [BIT_W-1:0]  bitk;
  logic [ECNT_W-1:0] ecnt;
  logic              accept;
  logic              start;
  logic              tick;
  logic [IDX_W-1:0]  run_idx;
  logic [IDX_W-1:0]  first_idx;
  logic [BIT_W-1:0]  new_nbits;
  logic [ECNT_W-1:0] edge_total;

  spim_cfg_bank #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wsel (cfg_sel),
    .wdata(cfg_data),
    .rsel (in_slot),
    .rcfg (sel_cfg)
  );

  spim_halfper #(.HW(HALF_W)) u_half (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .restart(start),
    .half   (cur_half),
    .tick   (tick)
  );

  spim_bitpos u_pos_run (
    .k    (bitk),
    .nbits(cur_nbits),
    .lsb  (cur_lsb),
    .idx  (run_idx)
  );

  spim_bitpos u_pos_first (
    .k    ('0),
    .nbits(new_nbits),
    .lsb  (sel_cfg.lsb),
    .idx  (first_idx)
  );

  assign in_ready   = !busy;
  assign accept     = in_valid && !busy;
  assign start      = accept && sel_cfg.en;
  assign new_nbits  = len_bits(sel_cfg.len);
  assign edge_total = {cur_nbits, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cs_n      <= '1;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      out_slot  <= '0;
      out_data  <= '0;
      cur_slot  <= '0;
      cur_nbits <= BIT_W'(8);
      cur_lsb   <= 1'b0;
      cur_lb    <= 1'b0;
      cur_half  <= HALF_W'(1);
      txd       <= '0;
      rxd       <= '0;
      bitk      <= '0;
      ecnt      <= '0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        cs_n      <= ~(NSLOTS'(1) << in_slot);
        sclk      <= sel_cfg.cpol;
        mosi      <= in_data[first_idx];
        cur_slot  <= in_slot;
        cur_nbits <= new_nbits;
        cur_lsb   <= sel_cfg.lsb;
        cur_lb    <= sel_cfg.lb;
        cur_half  <= half_of(sel_cfg.div);
        txd       <= in_data;
        rxd       <= '0;
        bitk      <= '0;
        ecnt      <= '0;
      end else if (tick) begin
        if (ecnt < edge_total) begin
          sclk <= !sclk;
          ecnt <= ecnt + ECNT_W'(1);
          if (!sclk) begin
            rxd[run_idx] <= cur_lb ? mosi : miso;
            bitk         <= bitk + BIT_W'(1);
          end else if ((bitk != '0) && (bitk < cur_nbits)) begin
            mosi <= txd[run_idx];
          end
        end else begin
          busy      <= 1'b0;
          cs_n      <= '1;
          out_valid <= 1'b1;
          done      <= 1'b1;
          out_slot  <= cur_slot;
          out_data  <= rxd;
        end
      end
    end
  end
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk #(
  parameter int NSLOTS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [NSLOTS-1:0] cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              out_valid,
  input logic              in_valid,
  input logic              in_ready,
  input logic              sel_en
);
  // R2: never more than one peripheral selected
  a_r2_one_slot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R2: busy covers exactly the selected interval
  a_r2_busy_with_cs: assert property (@(posedge clk) disable iff (rst)
    busy == (cs_n != '1));

  // R8: result strobe coincides with release
  a_r8_result_at_release: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid);

  a_r8_no_stray_result: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);

  // R9: word for a disabled slot leaves the bus idle
  a_r9_disabled_drop: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !sel_en) |=> (!busy && cs_n == '1));

  // R7: data out holds while SCLK stays high during a transfer
  a_r7_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sclk && $past(sclk)) |-> $stable(mosi));

  // R6: no SCLK activity between transfers
  a_r6_idle_sclk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(sclk));
endmodule

bind spim_master spim_master_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .out_valid(out_valid),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sel_en   (sel_cfg.en)
);

// File: tb/sim_spim_master.sv
`timescale 1ns/1ps
module sim_spim_master;
  localparam int NS = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [31:0]   cfg_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_slot = '0;
  logic [31:0]   in_data = '0;
  logic          out_valid;
  logic [SW-1:0] out_slot;
  logic [31:0]   out_data;
  logic          done;
  logic          busy;
  logic          sclk;
  logic          mosi;
  logic          miso;
  logic [NS-1:0] cs_n;

  assign miso = ~mosi;

  always #4 clk = ~clk;

  spim_master #(.NSLOTS(NS)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_slot(in_slot), .in_data(in_data),
    .out_valid(out_valid), .out_slot(out_slot), .out_data(out_data), .done(done),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  typedef struct {
    logic [SW-1:0] slot;
    logic [31:0]   data;
    int            nbits;
    logic [31:0]   serial;
    int            half;
    logic          cpol;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] shadow [NS];
  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int nout = 0;
  int idle_toggles = 0;
  int act_cycles = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input logic [1:0] mode, input logic [1:0] len,
                                     input bit lsb, input bit lb, input logic [15:0] div);
    return {div, 9'b0, lb, lsb, len, mode, en};
  endfunction

  function automatic exp_t predict(input logic [SW-1:0] s, input logic [31:0] d);
    exp_t e;
    logic [31:0] w, m, v;
    int dv;
    w = shadow[s];
    e.slot  = s;
    e.nbits = (w[4:3] == 2'b00) ? 32 : (w[4:3] == 2'b01) ? 16 : 8;
    m = (e.nbits == 32) ? 32'hffff_ffff : ((32'h1 << e.nbits) - 1);
    v = d & m;
    e.data = w[6] ? v : (~d & m);
    e.serial = 32'h0;
    if (w[5]) begin
      for (int i = 0; i < e.nbits; i++) e.serial[e.nbits-1-i] = v[i];
    end else
      e.serial = v;
    dv = int'(w[31:16]);
    if (dv < 2) dv = 2;
    e.half = dv / 2;
    e.cpol = (w[2:1] == 2'b11);
    return e;
  endfunction

  task automatic write_cfg(input int s, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SW'(s); cfg_data = w;
    shadow[s] = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int s, input logic [31:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_slot = SW'(s); in_data = d;
    if (shadow[s][0]) sb.push_back(predict(SW'(s), d));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while ((sb.size() != 0 || busy) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // monitor and scoreboard
  bit          prev_act = 0;
  logic        prev_sclk = 0;
  int          t_cs, first_e, last_e, last_rise, per, nrise;
  logic [31:0] ser;
  logic        lead_sclk;
  logic [NS-1:0] cs_seen;

  always @(negedge clk) begin
    bit act;
    cyc++;
    act = !rst && (cs_n != '1);
    if (act) act_cycles++;
    if (!rst && !act && !prev_act && sclk != prev_sclk) idle_toggles++;
    if (act && !prev_act) begin
      t_cs = cyc; nrise = 0; ser = 0; first_e = -1; last_e = -1;
      last_rise = -1; per = -1; lead_sclk = sclk; cs_seen = cs_n;
    end else if (act && sclk != prev_sclk) begin
      if (first_e < 0) first_e = cyc;
      last_e = cyc;
      if (sclk) begin
        nrise++;
        ser = {ser[30:0], mosi};
        if (last_rise >= 0) per = cyc - last_rise;
        last_rise = cyc;
      end
    end
    if (!rst && out_valid) begin
      nout++;
      if (sb.size() == 0) begin
        check(0, "R9 unexpected result", {29'b0, out_slot}, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_slot == e.slot, "R8 result slot", {29'b0, out_slot}, {29'b0, e.slot});
        check(out_data == e.data, "R3/R5 received data", out_data, e.data);
        check(nrise == e.nbits, "R3 rising edge count", nrise, e.nbits);
        check(ser == e.serial, "R4 serial order on mosi", ser, e.serial);
        check(first_e - t_cs == e.half, "R6 lead time", first_e - t_cs, e.half);
        check(per == 2 * e.half, "R6 sclk period", per, 2 * e.half);
        check(cyc - last_e == e.half, "R6 trail time", cyc - last_e, e.half);
        check(cs_seen == ~(NS'(1) << e.slot), "R2 chip select line", {24'b0, cs_seen}, {24'b0, ~(NS'(1) << e.slot)});
        check(lead_sclk == e.cpol && sclk == e.cpol, "R7 sclk idle level", {30'b0, lead_sclk, sclk}, {30'b0, e.cpol, e.cpol});
        check(done && !busy && cs_n == '1, "R8 done with release", {30'b0, done, busy}, 32'h2);
      end
    end
    prev_act = act;
    prev_sclk = sclk;
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", cyc, 150000);
    summary();
  end

  initial begin
    int snap_out, snap_act, snap_idle;
    for (int i = 0; i < NS; i++) shadow[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R2 and R8
    check(cs_n == '1, "R2 reset chip selects", {24'b0, cs_n}, 32'hff);
    check(!busy && in_ready, "R2 reset idle", {30'b0, busy, in_ready}, 32'h1);
    check(!out_valid && !done, "R8 reset no result", {30'b0, out_valid, done}, 32'h0);

    // R1 R3 R5: 32-bit loopback, msb first, divider 4
    write_cfg(0, mk(1, 2'b00, 2'b00, 0, 1, 16'd4));
    send(0, 32'h5aa5_5aa5);
    drain();
    // R3: 8-bit and 16-bit words, upper input bits discarded
    write_cfg(1, mk(1, 2'b00, 2'b10, 0, 1, 16'd8));
    write_cfg(2, mk(1, 2'b00, 2'b01, 0, 1, 16'd16));
    send(1, 32'h1234_565a);
    send(2, 32'hdead_5aa5);
    drain();
    // R4: lsb first
    write_cfg(3, mk(1, 2'b00, 2'b00, 1, 1, 16'd4));
    send(3, 32'hff00_0000);
    send(3, 32'h0000_00c3);
    drain();
    // R7: mode 3
    write_cfg(4, mk(1, 2'b11, 2'b00, 0, 1, 16'd8));
    send(4, 32'h0102_0304);
    drain();
    // R5: pin receive, miso is inverted mosi
    write_cfg(5, mk(1, 2'b11, 2'b01, 1, 0, 16'd4));
    send(5, 32'h0000_1f30);
    drain();
    // R6: divider clamp and slow clock
    write_cfg(6, mk(1, 2'b00, 2'b10, 0, 0, 16'd0));
    write_cfg(7, mk(1, 2'b00, 2'b00, 0, 1, 16'd128));
    send(6, 32'h0000_0096);
    send(7, 32'h8000_0001);
    drain();
    // R9: disabled slot
    write_cfg(6, mk(0, 2'b00, 2'b00, 0, 1, 16'd4));
    snap_out = nout; snap_act = act_cycles; snap_idle = idle_toggles;
    send(6, 32'h1234_5678);
    repeat (40) @(negedge clk);
    check(nout == snap_out, "R9 no result for disabled slot", nout, snap_out);
    check(act_cycles == snap_act && cs_n == '1, "R9 no chip select", act_cycles, snap_act);
    check(idle_toggles == snap_idle && !busy, "R9 no sclk activity", idle_toggles, snap_idle);
    // R10: rewrite during transfer, then next word uses new settings
    write_cfg(0, mk(1, 2'b00, 2'b00, 0, 1, 16'd8));
    send(0, 32'h0000_0001);
    write_cfg(0, mk(1, 2'b11, 2'b01, 1, 0, 16'd4));
    check(busy, "R10 rewrite lands mid-transfer", {31'b0, busy}, 32'h1);
    send(0, 32'h0000_0002);
    drain();
    // back-to-back across slots with different formats
    send(3, 32'h0102_0304);
    send(1, 32'h0000_00a5);
    send(4, 32'h5aa5_5aa5);
    drain();
    check(sb.size() == 0, "R8 all results returned", sb.size(), 0);
    summary();
  end
endmodule